// File: doc/BRIEF.md
# Circular Line Buffer Vertical Upscaler

This block sits between a digitizer that captures a low-resolution progressive retro video signal and a high-definition raster generator. Captured RGB pixels arrive one source line at a time and are kept in a ring of line slots a few dozen lines deep. The output raster reads each stored line back on an integer number of consecutive output lines and repeats every stored pixel an integer number of times along the line. Output lines above and below the scaled picture, and pixels past the right edge of a stored line, are black. A ring is needed rather than a single line doubler because the active part of the source frame and the active part of the high-definition frame take up different fractions of a shared frame period. The latency this adds is therefore a handful of source lines, well under one output frame.

The writer counts incoming pixels into line slots. A line only becomes readable once its last pixel is stored. The reader starts a new group of repeated lines at the top of the scaled window, and again each time a group ends. If no complete unread line exists at that moment, it raises an underrun indication, keeps showing the line it already has, and tries again on the next output line. When the ring is full, an incoming line is discarded whole, so the slot on screen is never overwritten.

Top module: `line_ring_upscaler`

## Requirements
- R1: While reset is held, and before any output line has been started, `dst_pix_vld`, `dst_underrun` and `dst_pix` are all zero.
- R2: Each run of LINE_PIX valid source pixels forms one stored line. Stored lines are shown in arrival order. Slot pointers wrap modulo DEPTH, so the ring can be reused indefinitely.
- R3: When a new source line begins while DEPTH-1 complete unread lines are held, that whole line is discarded. The lines already held, and later lines that fit, are shown unchanged.
- R4: `dst_line_start` together with `dst_frame_start` gives the new output line index 0. `dst_line_start` alone adds one to the index.
- R5: Output lines with an index in [V_START, V_START + SRC_LINES*SCALE) form the scaled window. Every pixel on any other line is 0 (black).
- R6: A new stored line is fetched on the first window line, and then after each SCALE window lines. Each fetched line is therefore shown on SCALE consecutive output lines.
- R7: A fetch that finds no complete unread line sets `dst_underrun` for that whole output line. The previously fetched line is shown again, or black if none has ever been fetched. The fetch is retried on every following window line until it succeeds.
- R8: Along an output line, stored pixel k is emitted for pixel requests k*HREP through k*HREP+HREP-1. Requests past LINE_PIX*HREP return 0.
- R9: `dst_pix_vld` is high exactly one cycle after a cycle in which `dst_pix_req` is high, and `dst_pix` carries that request's pixel in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for both sides |
| rst_n | input | 1 | Asynchronous active-low reset, released on the clock |
| src_pix_vld | input | 1 | Source pixel strobe |
| src_pix | input | PIX_W | Source RGB pixel |
| dst_line_start | input | 1 | Pulse at the start of each output line; `dst_pix_req` must be low in this cycle |
| dst_frame_start | input | 1 | Marks the line started in the same cycle as output line 0 |
| dst_pix_req | input | 1 | Request for the next output pixel of the current line |
| dst_pix | output | PIX_W | Output pixel, valid with `dst_pix_vld` |
| dst_pix_vld | output | 1 | Output pixel valid |
| dst_underrun | output | 1 | High for an output line on which a fetch found the ring empty |

## Verification
The hardest condition to reach is starvation in the middle of the window, followed by recovery. The reader must retry fetches line after line, and then begin a fresh group of SCALE lines at an arbitrary offset inside the window. The bench reaches this by starting an output frame with the ring nearly drained and feeding one source line only partway down the window. In another phase it fills the ring until a line is dropped while a line is on screen. A per-line reference model of slot contents decides every expected pixel.

// File: rtl/vscale_pkg.sv
package vscale_pkg;

  // Outcome of the decision taken when an output line starts.
  typedef enum logic [1:0] {
    FETCH_NONE   = 2'd0,
    FETCH_TAKE   = 2'd1,
    FETCH_STARVE = 2'd2
  } fetch_e;

endpackage

// File: rtl/vscale_line_store.sv
module vscale_line_store #(
  parameter int PIX_W  = 24,
  parameter int WORDS  = 1536,
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [PIX_W-1:0]  wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [PIX_W-1:0]  rdata
);

  logic [PIX_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/vscale_line_writer.sv
module vscale_line_writer #(
  parameter int PIX_W    = 24,
  parameter int LINE_PIX = 64,
  parameter int DEPTH    = 24,
  parameter int SLOT_W   = 5,
  parameter int PIDX_W   = 6,
  parameter int ADDR_W   = 11,
  parameter int AV_W     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_pix_vld,
  input  logic [PIX_W-1:0]  src_pix,
  input  logic [AV_W-1:0]   avail,
  output logic              we,
  output logic [ADDR_W-1:0] waddr,
  output logic [PIX_W-1:0]  wdata,
  output logic              commit,
  output logic [SLOT_W-1:0] tail_slot
);

  logic [PIDX_W-1:0] pcnt_q, pcnt_d;
  logic [SLOT_W-1:0] tail_q, tail_d;
  logic              drop_q, drop_d;
  logic              first, last, full, drop_now;

  always_comb begin
    first    = (pcnt_q == '0);
    last     = (pcnt_q == PIDX_W'(LINE_PIX - 1));
    full     = (avail >= AV_W'(DEPTH - 1));
    drop_now = first ? full : drop_q;

    we     = src_pix_vld && !drop_now;
    commit = src_pix_vld && last && !drop_now;
    waddr  = ADDR_W'(tail_q) * ADDR_W'(LINE_PIX) + ADDR_W'(pcnt_q);
    wdata  = src_pix;

    pcnt_d = pcnt_q;
    drop_d = drop_q;
    tail_d = tail_q;
    if (src_pix_vld) begin
      pcnt_d = last ? '0 : pcnt_q + 1'b1;
      if (first) drop_d = full;
    end
    if (commit) begin
      tail_d = (tail_q == SLOT_W'(DEPTH - 1)) ? '0 : tail_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
      tail_q <= '0;
      drop_q <= 1'b0;
    end else begin
      pcnt_q <= pcnt_d;
      tail_q <= tail_d;
      drop_q <= drop_d;
    end
  end

  assign tail_slot = tail_q;

endmodule

// File: rtl/vscale_raster_reader.sv
module vscale_raster_reader
  import vscale_pkg::*;
#(
  parameter int PIX_W     = 24,
  parameter int LINE_PIX  = 64,
  parameter int DEPTH     = 24,
  parameter int SCALE     = 4,
  parameter int HREP      = 4,
  parameter int V_START   = 60,
  parameter int SRC_LINES = 240,
  parameter int LCNT_W    = 11,
  parameter int SLOT_W    = 5,
  parameter int PIDX_W    = 6,
  parameter int ADDR_W    = 11,
  parameter int AV_W      = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_start,
  input  logic              frame_start,
  input  logic              pix_req,
  input  logic [AV_W-1:0]   avail,
  input  logic [PIX_W-1:0]  rdata,
  output logic              take,
  output logic              rd_en,
  output logic [ADDR_W-1:0] raddr,
  output logic [PIX_W-1:0]  dst_pix,
  output logic              dst_pix_vld,
  output logic              dst_underrun,
  output logic [SLOT_W-1:0] cur_slot,
  output logic              have_line,
  output logic              in_window
);

  localparam int V_END  = V_START + SRC_LINES * SCALE;
  localparam int REP_W  = (SCALE > 1) ? $clog2(SCALE) : 1;
  localparam int HSUB_W = (HREP > 1) ? $clog2(HREP) : 1;
  localparam int SIDX_W = PIDX_W + 1;

  logic [LCNT_W-1:0] line_q, line_d, nidx;
  logic [REP_W-1:0]  rep_q, rep_d;
  logic [SLOT_W-1:0] head_q, head_d, cur_q, cur_d;
  logic              have_q, have_d, act_q, act_d, under_q, under_d;
  logic [HSUB_W-1:0] hsub_q, hsub_d;
  logic [SIDX_W-1:0] sidx_q, sidx_d;
  logic              show_q, show_d, vld_q, vld_d;
  logic              win, need, in_range, last_sub;
  fetch_e            fetch;

  // line-start decision
  always_comb begin
    nidx = frame_start ? '0 : line_q + 1'b1;
    win  = (int'(nidx) >= V_START) && (int'(nidx) < V_END);
    need = win && ((int'(nidx) == V_START) || (rep_q == REP_W'(SCALE - 1)));
    if (!need)            fetch = FETCH_NONE;
    else if (avail != '0) fetch = FETCH_TAKE;
    else                  fetch = FETCH_STARVE;
    take = line_start && (fetch == FETCH_TAKE);
  end

  // pixel path
  always_comb begin
    in_range = (sidx_q < SIDX_W'(LINE_PIX));
    last_sub = (hsub_q == HSUB_W'(HREP - 1));
    rd_en    = pix_req && in_range;
    raddr    = ADDR_W'(cur_q) * ADDR_W'(LINE_PIX) + ADDR_W'(sidx_q[PIDX_W-1:0]);
  end

  // next state
  always_comb begin
    line_d  = line_q;
    rep_d   = rep_q;
    head_d  = head_q;
    cur_d   = cur_q;
    have_d  = have_q;
    act_d   = act_q;
    under_d = under_q;
    hsub_d  = hsub_q;
    sidx_d  = sidx_q;
    show_d  = 1'b0;
    vld_d   = pix_req;

    if (line_start) begin
      line_d  = nidx;
      act_d   = win;
      under_d = (fetch == FETCH_STARVE);
      hsub_d  = '0;
      sidx_d  = '0;
      unique case (fetch)
        FETCH_TAKE: begin
          rep_d  = '0;
          cur_d  = head_q;
          have_d = 1'b1;
          head_d = (head_q == SLOT_W'(DEPTH - 1)) ? '0 : head_q + 1'b1;
        end
        FETCH_STARVE: rep_d = REP_W'(SCALE - 1);
        default:      rep_d = win ? rep_q + 1'b1 : '0;
      endcase
    end else if (pix_req) begin
      show_d = in_range && act_q && have_q;
      hsub_d = last_sub ? '0 : hsub_q + 1'b1;
      if (last_sub && in_range) sidx_d = sidx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q  <= '0;
      rep_q   <= '0;
      head_q  <= '0;
      cur_q   <= '0;
      have_q  <= 1'b0;
      act_q   <= 1'b0;
      under_q <= 1'b0;
      hsub_q  <= '0;
      sidx_q  <= '0;
      show_q  <= 1'b0;
      vld_q   <= 1'b0;
    end else begin
      line_q  <= line_d;
      rep_q   <= rep_d;
      head_q  <= head_d;
      cur_q   <= cur_d;
      have_q  <= have_d;
      act_q   <= act_d;
      under_q <= under_d;
      hsub_q  <= hsub_d;
      sidx_q  <= sidx_d;
      show_q  <= show_d;
      vld_q   <= vld_d;
    end
  end

  assign dst_pix      = show_q ? rdata : '0;
  assign dst_pix_vld  = vld_q;
  assign dst_underrun = under_q;
  assign cur_slot     = cur_q;
  assign have_line    = have_q;
  assign in_window    = act_q;

endmodule

// File: rtl/line_ring_upscaler.sv
module line_ring_upscaler #(
  parameter int PIX_W     = 24,
  parameter int LINE_PIX  = 64,
  parameter int DEPTH     = 24,
  parameter int SCALE     = 4,
  parameter int HREP      = 4,
  parameter int V_START   = 60,
  parameter int SRC_LINES = 240,
  parameter int LCNT_W    = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_pix_vld,
  input  logic [PIX_W-1:0] src_pix,
  input  logic             dst_line_start,
  input  logic             dst_frame_start,
  input  logic             dst_pix_req,
  output logic [PIX_W-1:0] dst_pix,
  output logic             dst_pix_vld,
  output logic             dst_underrun
);

  localparam int WORDS  = DEPTH * LINE_PIX;
  localparam int ADDR_W = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int PIDX_W = (LINE_PIX > 1) ? $clog2(LINE_PIX) : 1;
  localparam int AV_W   = $clog2(DEPTH + 1);

  logic              rst_meta_q, rst_sync_n;
  logic [AV_W-1:0]   avail_q, avail_d;
  logic              we, commit, take, rd_en;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [PIX_W-1:0]  wdata, rdata;
  logic [SLOT_W-1:0] tail_slot, cur_slot;
  logic              have_line, in_window;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // complete unread lines in the ring
  always_comb begin
    avail_d = avail_q + AV_W'(commit) - AV_W'(take);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) avail_q <= '0;
    else             avail_q <= avail_d;
  end

  vscale_line_store #(
    .PIX_W(PIX_W), .WORDS(WORDS), .ADDR_W(ADDR_W)
  ) u_store (
    .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
    .re(rd_en), .raddr(raddr), .rdata(rdata)
  );

  vscale_line_writer #(
    .PIX_W(PIX_W), .LINE_PIX(LINE_PIX), .DEPTH(DEPTH), .SLOT_W(SLOT_W),
    .PIDX_W(PIDX_W), .ADDR_W(ADDR_W), .AV_W(AV_W)
  ) u_writer (
    .clk(clk), .rst_n(rst_sync_n), .src_pix_vld(src_pix_vld), .src_pix(src_pix),
    .avail(avail_q), .we(we), .waddr(waddr), .wdata(wdata), .commit(commit),
    .tail_slot(tail_slot)
  );

  vscale_raster_reader #(
    .PIX_W(PIX_W), .LINE_PIX(LINE_PIX), .DEPTH(DEPTH), .SCALE(SCALE), .HREP(HREP),
    .V_START(V_START), .SRC_LINES(SRC_LINES), .LCNT_W(LCNT_W), .SLOT_W(SLOT_W),
    .PIDX_W(PIDX_W), .ADDR_W(ADDR_W), .AV_W(AV_W)
  ) u_reader (
    .clk(clk), .rst_n(rst_sync_n), .line_start(dst_line_start),
    .frame_start(dst_frame_start), .pix_req(dst_pix_req), .avail(avail_q),
    .rdata(rdata), .take(take), .rd_en(rd_en), .raddr(raddr), .dst_pix(dst_pix),
    .dst_pix_vld(dst_pix_vld), .dst_underrun(dst_underrun), .cur_slot(cur_slot),
    .have_line(have_line), .in_window(in_window)
  );

endmodule

// File: rtl/line_ring_upscaler_chk.sv
module line_ring_upscaler_chk #(
  parameter int DEPTH  = 24,
  parameter int AV_W   = 5,
  parameter int SLOT_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dst_pix_req,
  input logic              dst_pix_vld,
  input logic              dst_line_start,
  input logic              dst_underrun,
  input logic [AV_W-1:0]   avail,
  input logic              we,
  input logic [SLOT_W-1:0] wslot,
  input logic [SLOT_W-1:0] cur_slot,
  input logic              have_line,
  input logic              in_window
);

  assert_vld_follows_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dst_pix_req |=> dst_pix_vld);

  assert_vld_needs_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !dst_pix_req |=> !dst_pix_vld);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    avail <= AV_W'(DEPTH - 1));

  assert_shown_slot_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (we && have_line) |-> (wslot != cur_slot));

  assert_underrun_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !dst_line_start |=> $stable(dst_underrun));

  assert_underrun_in_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dst_underrun |-> in_window);

  assert_underrun_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dst_underrun) |-> ($past(avail) == '0));

endmodule

bind line_ring_upscaler line_ring_upscaler_chk #(
  .DEPTH(DEPTH), .AV_W(AV_W), .SLOT_W(SLOT_W)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .dst_pix_req(dst_pix_req),
  .dst_pix_vld(dst_pix_vld), .dst_line_start(dst_line_start),
  .dst_underrun(dst_underrun), .avail(avail_q), .we(we), .wslot(tail_slot),
  .cur_slot(cur_slot), .have_line(have_line), .in_window(in_window)
);

// File: tb/line_ring_upscaler_test.sv
`timescale 1ns/1ps
module line_ring_upscaler_test;

  localparam int PIX_W = 16;
  localparam int LP    = 4;
  localparam int DP    = 4;
  localparam int SC    = 3;
  localparam int HR    = 2;
  localparam int VS    = 2;
  localparam int SL    = 5;
  localparam int VE    = VS + SL * SC;
  localparam int NREQ  = LP * HR + 2;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             src_pix_vld, dst_line_start, dst_frame_start, dst_pix_req;
  logic [PIX_W-1:0] src_pix, dst_pix;
  logic             dst_pix_vld, dst_underrun;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  int q [DP];
  int avail_m = 0, head_m = 0, tail_m = 0;
  int cur_m = 0, have_m = 0, line_m = 0, rep_m = 0;
  int next_id = 1;

  always #2.5 clk = ~clk;

  line_ring_upscaler #(
    .PIX_W(PIX_W), .LINE_PIX(LP), .DEPTH(DP), .SCALE(SC), .HREP(HR),
    .V_START(VS), .SRC_LINES(SL), .LCNT_W(6)
  ) uut (
    .clk(clk), .rst_n(rst_n), .src_pix_vld(src_pix_vld), .src_pix(src_pix),
    .dst_line_start(dst_line_start), .dst_frame_start(dst_frame_start),
    .dst_pix_req(dst_pix_req), .dst_pix(dst_pix), .dst_pix_vld(dst_pix_vld),
    .dst_underrun(dst_underrun)
  );

  function automatic int pixval(int id, int p);
    return ((id & 255) << 8) | p;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R2/R3: push one source line, dropped when the ring holds DP-1 unread lines
  task automatic write_line();
    int id = next_id;
    next_id++;
    for (int p = 0; p < LP; p++) begin
      @(negedge clk);
      src_pix_vld = 1'b1;
      src_pix     = PIX_W'(pixval(id, p));
    end
    @(negedge clk);
    src_pix_vld = 1'b0;
    if (avail_m < DP - 1) begin
      q[tail_m] = id;
      tail_m = (tail_m + 1) % DP;
      avail_m++;
    end
  endtask

  // R4..R9: one output line, every pixel checked against the model
  task automatic out_line(bit fs);
    int nidx, win, need, under, act, exp;
    nidx = fs ? 0 : line_m + 1;
    line_m = nidx;
    win  = (nidx >= VS) && (nidx < VE);
    need = win && ((nidx == VS) || (rep_m == SC - 1));
    under = 0;
    if (need) begin
      if (avail_m > 0) begin
        cur_m = q[head_m];
        head_m = (head_m + 1) % DP;
        avail_m--;
        have_m = 1;
        rep_m = 0;
      end else begin
        under = 1;
        rep_m = SC - 1;
      end
    end else begin
      rep_m = win ? rep_m + 1 : 0;
    end
    act = win && have_m;

    @(negedge clk);
    dst_line_start  = 1'b1;
    dst_frame_start = fs;
    @(negedge clk);
    dst_line_start  = 1'b0;
    dst_frame_start = 1'b0;
    check(dst_underrun == under, "R7 underrun flag", dst_underrun, under);
    for (int r = 0; r < NREQ; r++) begin
      dst_pix_req = 1'b1;
      @(negedge clk);
      dst_pix_req = 1'b0;
      exp = (act && (r / HR) < LP) ? pixval(cur_m, r / HR) : 0;
      check(dst_pix_vld == 1'b1, "R9 pixel valid", dst_pix_vld, 1);
      if (!win)
        check(int'(dst_pix) == exp, "R5 black outside window", dst_pix, exp);
      else if (r / HR >= LP)
        check(int'(dst_pix) == exp, "R8 black past line end", dst_pix, exp);
      else
        check(int'(dst_pix) == exp, "R6 R8 repeated pixel", dst_pix, exp);
    end
    @(negedge clk);
    check(dst_pix_vld == 1'b0, "R9 valid drops", dst_pix_vld, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    src_pix_vld = 1'b0;
    src_pix = '0;
    dst_line_start = 1'b0;
    dst_frame_start = 1'b0;
    dst_pix_req = 1'b0;
    repeat (3) @(negedge clk);
    check(dst_pix_vld == 1'b0, "R1 reset valid", dst_pix_vld, 0);
    check(dst_underrun == 1'b0, "R1 reset underrun", dst_underrun, 0);
    check(dst_pix == '0, "R1 reset pixel", dst_pix, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(dst_pix_vld == 1'b0, "R1 idle valid", dst_pix_vld, 0);

    // empty ring: window lines starve and stay black (R7)
    out_line(1'b1);
    for (int k = 1; k < 4; k++) out_line(1'b0);

    // fill until a line is discarded (R3)
    for (int k = 0; k < 4; k++) write_line();

    // steady frame with writes interleaved, ring wraps (R2, R4, R6)
    out_line(1'b1);
    for (int k = 1; k < VE + 3; k++) begin
      out_line(1'b0);
      if (k % 2 == 0) write_line();
    end

    // starved frame, one line arriving mid-window (R7 retry)
    out_line(1'b1);
    for (int k = 1; k < VE + 3; k++) begin
      out_line(1'b0);
      if (k == 9) write_line();
    end

    // overfill while a line is on screen, then another frame (R3, R2)
    for (int k = 0; k < 5; k++) write_line();
    out_line(1'b1);
    for (int k = 1; k < VE + 2; k++) begin
      out_line(1'b0);
      if (k % 3 == 0) write_line();
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule